// File: doc/BRIEF.md
# Master Clock Ratio Detector and Word-Clock Lock Monitor

This block sits between the master (system) clock of an audio converter and its sample-rate word clock. It counts system-clock cycles across every word-clock period and sorts the result into one of three supported ratios: 256, 384 or 512 times the sample rate. From the ratio it derives a single clock enable that fires at an average of 256 pulses per sample period. The decimation filters, interpolation filters and modulators all run from this enable, so they see the same timing whichever master clock is fitted.

The block also watches whether the word clock stays locked to the system clock. The measure is the number of bit-clock edges in each sample period, compared against a reference learned once lock is reached. A period whose count strays by six or more bit clocks, a period length outside every ratio window, or a word clock that stops, each raises a hold output. Converter datapaths use hold to force the playback output to midscale and the recorded output code to zero. Hold is released only after a run of clean periods.

Word clock and bit clock are sampled into the system-clock domain through a synchronizer. No phase relation to the system clock is assumed.

Top module: `mclk_ratio_monitor`

## Requirements
- R1: While reset is asserted and right after its release, `hold` is 1, `ratio_code` is 0 and `en_256fs` is 0.
- R2: `ratio_code` is 1 for 256, 2 for 384 and 3 for 512 system clocks per word-clock period. A count within ±2 cycles of the nominal value is accepted. The code becomes valid only after two consecutive measured periods fall into the same class. `ratio_ok` is 1 exactly when `ratio_code` is nonzero.
- R3: A measured period outside every tolerance window makes `ratio_code` 0 and keeps `hold` at 1.
- R4: `en_256fs` is 0 while the ratio is invalid. At code 1 it is high every cycle. At code 2 it is high on two of every three cycles, with no run longer than two. At code 3 it is high on every second cycle. In each case there are 256 pulses per nominal period.
- R5: If the bit-clock count of a period differs from the learned reference by 6 or more, `hold` rises at the word-clock edge that ends that period, and the reference is relearned from the next period.
- R6: A bit-clock count within 5 of the reference has no effect on `hold` or the reference.
- R7: After any loss, `hold` falls only when 4 consecutive good periods have been measured, counting the period that relearns the reference. 4 is the parameter default.
- R8: If no word-clock rising edge arrives for 1024 system clocks, `hold` is set and `ratio_code` returns to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System (master) clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wclk | input | 1 | Left/right word clock, one period per sample |
| bclk | input | 1 | Serial bit clock |
| ratio_code | output | 2 | Detected ratio: 0 invalid, 1 = 256, 2 = 384, 3 = 512 |
| ratio_ok | output | 1 | Ratio classification valid |
| en_256fs | output | 1 | Common 256-per-sample clock enable |
| hold | output | 1 | Force DAC to midscale and ADC code to zero |

## Verification
The bench targets the edges of the ±2 tolerance window (258 and 514 accepted, 259 and 381 rejected). A classifier with an off-by-one window would lock onto a stray clock or reject a legal one. It counts enable pulses over whole periods, including lengths that are not multiples of three, where a wrong cadence or a phase that is not restarted gives the wrong rate. It places drift exactly at 5 and 6 bit clocks: a design that compares with the wrong inequality either mutes on legal jitter or plays through a slip. It also times the release of hold to the exact period. A design that counts the relearning period wrongly releases one period early or late, and a missing stall timeout would leave the outputs live when the word clock stops.

// File: rtl/mrm_pkg.sv
package mrm_pkg;
  typedef enum logic [1:0] {
    RATIO_NONE = 2'd0,
    RATIO_256  = 2'd1,
    RATIO_384  = 2'd2,
    RATIO_512  = 2'd3
  } ratio_e;
endpackage

// File: rtl/mrm_edge_sync.sv
module mrm_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic rise
);
  logic [STAGES-1:0] sh_q, sh_d;
  logic              last_q;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], d};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      last_q <= 1'b0;
    end else begin
      sh_q   <= sh_d;
      last_q <= sh_q[STAGES-1];
    end
  end

  assign rise = sh_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/mrm_period_meter.sv
module mrm_period_meter
  import mrm_pkg::*;
#(
  parameter int BASE     = 256,
  parameter int TOL      = 2,
  parameter int TIMEOUT  = 1024,
  parameter int BITS_MAX = 255
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             w_rise,
  input  logic                             b_rise,
  output logic                             meas_stb,
  output logic [$clog2(BITS_MAX+1)-1:0]    bits,
  output ratio_e                           ratio,
  output logic                             timeout_stb
);
  localparam int CW   = $clog2(TIMEOUT + 2);
  localparam int BW   = $clog2(BITS_MAX + 1);
  localparam int N256 = BASE;
  localparam int N384 = (BASE * 3) / 2;
  localparam int N512 = BASE * 2;

  logic [CW-1:0] cnt_q, cnt_d, meas;
  logic [BW-1:0] bcnt_q, bcnt_d, bsum, bits_q, bits_d;
  logic          seen_q, seen_d, stb_q, stb_d, to_q, to_d;
  ratio_e        prev_q, prev_d, ratio_q, ratio_d, cls;

  function automatic logic in_win(input logic [CW-1:0] v, input int nom);
    return (v >= CW'(nom - TOL)) && (v <= CW'(nom + TOL));
  endfunction

  always_comb begin
    meas = cnt_q + CW'(1);
    if (in_win(meas, N256))      cls = RATIO_256;
    else if (in_win(meas, N384)) cls = RATIO_384;
    else if (in_win(meas, N512)) cls = RATIO_512;
    else                         cls = RATIO_NONE;
    bsum = (bcnt_q == BW'(BITS_MAX)) ? bcnt_q : bcnt_q + {{(BW-1){1'b0}}, b_rise};
    cnt_d   = (cnt_q == CW'(TIMEOUT)) ? cnt_q : cnt_q + CW'(1);
    bcnt_d  = bsum;
    seen_d  = seen_q;
    prev_d  = prev_q;
    ratio_d = ratio_q;
    bits_d  = bits_q;
    stb_d   = 1'b0;
    to_d    = 1'b0;
    if (w_rise) begin
      cnt_d  = '0;
      bcnt_d = '0;
      seen_d = 1'b1;
      if (seen_q) begin
        stb_d   = 1'b1;
        bits_d  = bsum;
        prev_d  = cls;
        ratio_d = (cls == prev_q && cls != RATIO_NONE) ? cls : RATIO_NONE;
      end
    end else if (cnt_q == CW'(TIMEOUT - 1)) begin
      to_d    = 1'b1;
      seen_d  = 1'b0;
      prev_d  = RATIO_NONE;
      ratio_d = RATIO_NONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      bcnt_q  <= '0;
      seen_q  <= 1'b0;
      prev_q  <= RATIO_NONE;
      ratio_q <= RATIO_NONE;
      bits_q  <= '0;
      stb_q   <= 1'b0;
      to_q    <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      bcnt_q  <= bcnt_d;
      seen_q  <= seen_d;
      prev_q  <= prev_d;
      ratio_q <= ratio_d;
      bits_q  <= bits_d;
      stb_q   <= stb_d;
      to_q    <= to_d;
    end
  end

  assign meas_stb    = stb_q;
  assign bits        = bits_q;
  assign ratio       = ratio_q;
  assign timeout_stb = to_q;

  assert_ratio_moves_on_event_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ratio_q) |-> ($past(w_rise) || ($past(cnt_q) == CW'(TIMEOUT - 1))));
endmodule

// File: rtl/mrm_lock_tracker.sv
module mrm_lock_tracker #(
  parameter int BW        = 8,
  parameter int DRIFT_MAX = 5,
  parameter int RECOV     = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          meas_stb,
  input  logic          ratio_ok,
  input  logic [BW-1:0] bits,
  input  logic          timeout_stb,
  output logic          hold
);
  localparam int GW = $clog2(RECOV + 1);

  logic [BW-1:0] ref_q, ref_d, diff;
  logic          have_q, have_d, hold_q, hold_d;
  logic [GW-1:0] good_q, good_d, good_inc;

  always_comb begin
    diff     = (bits >= ref_q) ? bits - ref_q : ref_q - bits;
    good_inc = (good_q == GW'(RECOV)) ? good_q : good_q + GW'(1);
    ref_d    = ref_q;
    have_d   = have_q;
    good_d   = good_q;
    if (timeout_stb) begin
      have_d = 1'b0;
      good_d = '0;
    end else if (meas_stb) begin
      if (!ratio_ok) begin
        have_d = 1'b0;
        good_d = '0;
      end else if (!have_q) begin
        ref_d  = bits;
        have_d = 1'b1;
        good_d = good_inc;
      end else if (diff > BW'(DRIFT_MAX)) begin
        have_d = 1'b0;
        good_d = '0;
      end else begin
        good_d = good_inc;
      end
    end
    hold_d = (good_d < GW'(RECOV));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_q  <= '0;
      have_q <= 1'b0;
      good_q <= '0;
      hold_q <= 1'b1;
    end else begin
      ref_q  <= ref_d;
      have_q <= have_d;
      good_q <= good_d;
      hold_q <= hold_d;
    end
  end

  assign hold = hold_q;

  assert_hold_on_drift_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (meas_stb && ratio_ok && have_q && !timeout_stb && diff > BW'(DRIFT_MAX)) |=> hold);
  assert_hold_on_bad_ratio_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (meas_stb && !ratio_ok) |=> hold);
  assert_hold_on_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_stb |=> hold);
  assert_release_at_measure_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hold) |-> $past(meas_stb));
endmodule

// File: rtl/mrm_rate_enable.sv
module mrm_rate_enable
  import mrm_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   w_rise,
  input  ratio_e ratio,
  output logic   en
);
  logic [1:0] ph_q, ph_d;

  always_comb begin
    if (w_rise)                  ph_d = 2'd0;
    else if (ratio == RATIO_384) ph_d = (ph_q >= 2'd2) ? 2'd0 : ph_q + 2'd1;
    else                         ph_d = (ph_q == 2'd0) ? 2'd1 : 2'd0;
    case (ratio)
      RATIO_256: en = 1'b1;
      RATIO_384: en = (ph_q != 2'd2);
      RATIO_512: en = (ph_q == 2'd0);
      default:   en = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= 2'd0;
    else        ph_q <= ph_d;
  end

  assert_en_512_alternates_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ratio == RATIO_512 && $stable(ratio) && en && !w_rise) |=> !en);
endmodule

// File: rtl/mclk_ratio_monitor.sv
module mclk_ratio_monitor
  import mrm_pkg::*;
#(
  parameter int BASE_RATIO    = 256,
  parameter int RATIO_TOL     = 2,
  parameter int TIMEOUT_CYC   = 1024,
  parameter int SYNC_STAGES   = 2,
  parameter int BITS_MAX      = 255,
  parameter int DRIFT_MAX     = 5,
  parameter int RECOV_PERIODS = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wclk,
  input  logic       bclk,
  output logic [1:0] ratio_code,
  output logic       ratio_ok,
  output logic       en_256fs,
  output logic       hold
);
  localparam int BW = $clog2(BITS_MAX + 1);

  logic          w_rise, b_rise, meas_stb, timeout_stb;
  logic [BW-1:0] bits;
  ratio_e        ratio;

  mrm_edge_sync #(.STAGES(SYNC_STAGES)) u_wsync (
    .clk(clk), .rst_n(rst_n), .d(wclk), .rise(w_rise));
  mrm_edge_sync #(.STAGES(SYNC_STAGES)) u_bsync (
    .clk(clk), .rst_n(rst_n), .d(bclk), .rise(b_rise));

  mrm_period_meter #(
    .BASE(BASE_RATIO), .TOL(RATIO_TOL), .TIMEOUT(TIMEOUT_CYC), .BITS_MAX(BITS_MAX)
  ) u_meter (
    .clk(clk), .rst_n(rst_n), .w_rise(w_rise), .b_rise(b_rise),
    .meas_stb(meas_stb), .bits(bits), .ratio(ratio), .timeout_stb(timeout_stb));

  mrm_lock_tracker #(.BW(BW), .DRIFT_MAX(DRIFT_MAX), .RECOV(RECOV_PERIODS)) u_lock (
    .clk(clk), .rst_n(rst_n), .meas_stb(meas_stb), .ratio_ok(ratio != RATIO_NONE),
    .bits(bits), .timeout_stb(timeout_stb), .hold(hold));

  mrm_rate_enable u_en (
    .clk(clk), .rst_n(rst_n), .w_rise(w_rise), .ratio(ratio), .en(en_256fs));

  assign ratio_code = ratio;
  assign ratio_ok   = (ratio != RATIO_NONE);
endmodule

// File: tb/sim_mclk_ratio_monitor.sv
module sim_mclk_ratio_monitor;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rst_n, wclk, bclk;
  logic [1:0] ratio_code;
  logic       ratio_ok, en_256fs, hold;

  mclk_ratio_monitor u0 (
    .clk(clk), .rst_n(rst_n), .wclk(wclk), .bclk(bclk),
    .ratio_code(ratio_code), .ratio_ok(ratio_ok), .en_256fs(en_256fs), .hold(hold));

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  int en_cnt, max_run;

  // period, bit clocks per period, expected ratio code
  localparam logic [19:0] VEC [8] = '{
    {10'd256, 8'd64, 2'd1},
    {10'd384, 8'd64, 2'd2},
    {10'd512, 8'd64, 2'd3},
    {10'd258, 8'd32, 2'd1},
    {10'd382, 8'd48, 2'd2},
    {10'd514, 8'd64, 2'd3},
    {10'd259, 8'd64, 2'd0},
    {10'd381, 8'd64, 2'd0}
  };

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic run_frame(input int p, input int nb);
    int run;
    run = 0; en_cnt = 0; max_run = 0;
    for (int c = 0; c < p; c++) begin
      @(negedge clk);
      if (en_256fs) begin
        en_cnt++; run++;
        if (run > max_run) max_run = run;
      end else run = 0;
      wclk = (c < p / 2);
      bclk = (c >= 1 && c < 1 + 2 * nb) ? ((c - 1) % 2 == 0) : 1'b0;
    end
  endtask

  function automatic int exp_en(input int p, input int r);
    case (r)
      1: return p;
      2: return 2 * (p / 3) + (p % 3);
      3: return p / 2 + p % 2;
      default: return 0;
    endcase
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wclk = 1'b0; bclk = 1'b0;
    repeat (3) @(negedge clk);
    check(hold == 1'b1, "R1 hold in reset", hold, 1);
    check(ratio_code == 2'd0, "R1 ratio in reset", ratio_code, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(hold == 1'b1 && en_256fs == 1'b0, "R1 hold/en after release", {hold, en_256fs}, 2);
    check(ratio_ok == 1'b0, "R1 ratio_ok after release", ratio_ok, 0);

    // table walk: settle 8 periods, then measure one
    for (int i = 0; i < 8; i++) begin
      int p, nb, r;
      p = int'(VEC[i][19:10]); nb = int'(VEC[i][9:2]); r = int'(VEC[i][1:0]);
      repeat (8) run_frame(p, nb);
      run_frame(p, nb);
      check(ratio_code == 2'(r), $sformatf("R2/R3 ratio p=%0d", p), ratio_code, r);
      check(ratio_ok == (r != 0), $sformatf("R2 ratio_ok p=%0d", p), ratio_ok, r != 0);
      check(hold == (r == 0), $sformatf("R3 hold p=%0d", p), hold, r == 0);
      check(en_cnt == exp_en(p, r), $sformatf("R4 enable count p=%0d", p), en_cnt, exp_en(p, r));
      if (p == 384) check(max_run == 2, "R4 384 run length", max_run, 2);
      if (p == 512) check(max_run == 1, "R4 512 run length", max_run, 1);
    end

    // R6: drift of 5 either way is tolerated
    repeat (8) run_frame(256, 64);
    check(hold == 1'b0, "R6 locked before drift", hold, 0);
    run_frame(256, 69);
    run_frame(256, 59);
    check(hold == 1'b0, "R6 drift +5/-5 ignored", hold, 0);
    run_frame(256, 64);
    run_frame(256, 64);
    check(hold == 1'b0, "R6 reference kept", hold, 0);

    // R5 / R7: drift of 6 then timed recovery
    run_frame(256, 70);
    run_frame(256, 64);
    check(hold == 1'b1, "R5 hold after +6 drift", hold, 1);
    run_frame(256, 64);
    run_frame(256, 64);
    run_frame(256, 64);
    check(hold == 1'b1, "R7 still held after 3 good", hold, 1);
    run_frame(256, 64);
    check(hold == 1'b0, "R7 released after 4 good", hold, 0);

    // R5: drift downward by 6
    run_frame(256, 58);
    run_frame(256, 64);
    check(hold == 1'b1, "R5 hold after -6 drift", hold, 1);
    repeat (5) run_frame(256, 64);
    check(hold == 1'b0, "R7 relocked", hold, 0);

    // R8: word clock stall
    wclk = 1'b0; bclk = 1'b0;
    repeat (1100) @(negedge clk);
    check(hold == 1'b1, "R8 hold after stall", hold, 1);
    check(ratio_code == 2'd0, "R8 ratio after stall", ratio_code, 0);
    check(en_256fs == 1'b0, "R4 enable off when invalid", en_256fs, 0);
    repeat (9) run_frame(512, 64);
    check(ratio_code == 2'd3 && hold == 1'b0, "R8 recovery after stall", {ratio_code, hold}, 6);

    // R1: reset during operation
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check(hold == 1'b1 && ratio_code == 2'd0, "R1 mid-run reset", {ratio_code, hold}, 1);
    rst_n = 1'b1;

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule